// File: doc/BRIEF.md
# SCSI Controller Host Register Front-End

This block is the part of a single-initiator SCSI protocol controller that faces the host processor. The host reaches it over a byte-wide access port with a 4-bit register index. Every index stands for two registers: one that host writes land in and one that host reads return. Behind one index sits a 16-byte data FIFO. A write to the command index is decoded at once. The block runs the housekeeping commands on its own: FIFO flush, chip reset, bus reset, attention set and clear, and message accept. Selection and transfer commands are passed on to a separate phase sequencer as a one-cycle start pulse.

The read side of the transfer counter changes only when a command arrives with its DMA flag set. A status register carries the interrupt flag, which drives a level interrupt pin. One read of the interrupt register acknowledges everything: it clears the interrupt, step and status registers together and leaves the command phase code in the status register. Each access takes one clock. Read data appears on the output in the cycle after the access.

Top module: `scsi_regfront`

## Requirements
- R1: After the reset input, and again after command code 0x02 (chip reset), the read side returns 0x94 at index 14, 0x02 at index 9 and 0x07 at index 8. Every other index reads 0x00, the FIFO is empty, and `irq`, `atn`, `link_up` and `seq_go` are low.
- R2: Writes to index 3 (command) and to indices 8 to 12 (configuration and test) read back unchanged from the same index. Writes to the counter indices 0, 1 and 14 do not change what those indices read.
- R3: Index 8 always reads the fixed controller bus ID (7) in bits 2:0. Bits 7:3 hold the last value written to that index.
- R4: Index 2 is a 16-entry byte FIFO. Writes push and reads pop in first-in first-out order, and the pointers wrap around. A write while 16 bytes are held is dropped.
- R5: Index 7 reads the step register bits 2:0 in bits 7:5 and the FIFO byte count in bits 4:0.
- R6: A read of index 2 while the FIFO is empty returns the byte that the previous FIFO read returned, and the count stays 0.
- R7: Command 0x01 empties the FIFO.
- R8: A command byte with bit 7 set copies the written counter bytes at indices 0, 1 and 14 to their read side. It also clears the terminal-count bit (bit 4) of the status register (index 4).
- R9: Any write to index 3 clears bit 7 (bus reset detected) of the interrupt register (index 5), unless the command is itself a bus reset.
- R10: Command 0x03 (bus reset) sets interrupt-register bits 7 and 3 and drops `link_up`. It sets the interrupt flag (status bit 7) only when bit 6 of the written index-8 value is 0. `irq` follows the status interrupt flag one clock after the flag changes.
- R11: A read of index 5 while status bit 7 is set returns the interrupt register's value before the clear. It then leaves index 5 and index 6 at 0x00 and index 4 at 0x02, and `irq` falls one clock later. A read of index 5 while status bit 7 is clear changes nothing.
- R12: Selection commands 0x41, 0x42, 0x43 and 0x46 (also with bit 7 set) raise `seq_go` for one cycle with the full command byte on `seq_cmd`, and set `link_up`. Transfer commands 0x10, 0x11 and 0x18 pulse `seq_go` only. Command 0x12 (message accept) sets interrupt bit 5 and status bit 7, loads 4 into the step register and drops `link_up`.
- R13: Command 0x1A sets the `atn` output and command 0x1B clears it.
- R14: Any command code not listed above sets interrupt-register bit 6 (illegal command) and status bit 7. Code 0x00 and code 0x44 do nothing beyond the effects common to every command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc | input | 1 | Register access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 4 | Register index |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read access |
| irq | output | 1 | Level interrupt, follows status bit 7 |
| atn | output | 1 | Attention flag |
| link_up | output | 1 | Connected to a target (set by selection, cleared by bus reset or message accept) |
| seq_go | output | 1 | One-cycle start pulse to the phase sequencer |
| seq_cmd | output | 8 | Command byte handed to the sequencer |

## Verification
The FIFO gets a short burst, then a 20-byte overfill that crosses the pointer wrap, then an empty read and a flush. These separate correct ordering from dropped or duplicated bytes, and a stale read from a pointer that moves. The bus-reset command is issued once with its interrupt mask clear and once with it set. Reading the interrupt register in both cases shows that the clear takes effect only while the interrupt flag is up. A no-operation command after the masked case isolates the bus-reset bit clear from the other interrupt bits. The counter indices are read after a plain command and after a DMA-flagged command, which shows that only the flag copies the counter bytes across.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int REG_NUM = 16;
  localparam int IDX_W   = 4;

  localparam logic [3:0] IX_TCL   = 4'd0;
  localparam logic [3:0] IX_TCM   = 4'd1;
  localparam logic [3:0] IX_FIFO  = 4'd2;
  localparam logic [3:0] IX_CMD   = 4'd3;
  localparam logic [3:0] IX_STAT  = 4'd4;
  localparam logic [3:0] IX_INTR  = 4'd5;
  localparam logic [3:0] IX_STEP  = 4'd6;
  localparam logic [3:0] IX_FLAGS = 4'd7;
  localparam logic [3:0] IX_CFG1  = 4'd8;
  localparam logic [3:0] IX_CLKF  = 4'd9;
  localparam logic [3:0] IX_CFG3  = 4'd12;
  localparam logic [3:0] IX_TCH   = 4'd14;

  localparam int ST_INT      = 7;
  localparam int ST_TC       = 4;
  localparam int IN_BUSRST   = 7;
  localparam int IN_ILLEGAL  = 6;
  localparam int IN_DISC     = 5;
  localparam int IN_FUNCDONE = 3;
  localparam int CF1_RSTMASK = 6;
  localparam int CMD_DMA     = 7;

  localparam logic [2:0] PHASE_CMD = 3'd2;
  localparam logic [2:0] STEP_DONE = 3'd4;

  typedef enum logic [3:0] {
    CK_NOP, CK_FLUSH, CK_CHIPRST, CK_BUSRST, CK_MSGOK,
    CK_SETATN, CK_CLRATN, CK_SELECT, CK_XFER, CK_ILLEGAL
  } cmd_kind_e;

  function automatic logic [7:0] wr_init(input logic [3:0] i);
    case (i)
      IX_TCH:  return 8'h94;
      IX_CLKF: return 8'h02;
      IX_STEP: return 8'h05;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic mirrored(input logic [3:0] i);
    return (i == IX_CMD) || (i >= IX_CFG1 && i <= IX_CFG3);
  endfunction
endpackage

// File: rtl/srf_cmd_decode.sv
module srf_cmd_decode
  import srf_pkg::*;
(
  input  logic [6:0] code,
  output cmd_kind_e  kind
);
  always_comb begin
    case (code)
      7'h00, 7'h44:               kind = CK_NOP;
      7'h01:                      kind = CK_FLUSH;
      7'h02:                      kind = CK_CHIPRST;
      7'h03:                      kind = CK_BUSRST;
      7'h12:                      kind = CK_MSGOK;
      7'h1a:                      kind = CK_SETATN;
      7'h1b:                      kind = CK_CLRATN;
      7'h41, 7'h42, 7'h43, 7'h46: kind = CK_SELECT;
      7'h10, 7'h11, 7'h18:        kind = CK_XFER;
      default:                    kind = CK_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/srf_fifo.sv
module srf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (do_pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> (count == '0 && $stable(rdata)));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
  import srf_pkg::*;
#(
  parameter int         FIFO_DEPTH = 16,
  parameter logic [2:0] BUS_ID     = 3'd7,
  localparam int        CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc,
  input  logic       acc_wr,
  input  logic [3:0] acc_idx,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic       irq,
  output logic       atn,
  output logic       link_up,
  output logic       seq_go,
  output logic [7:0] seq_cmd
);
  logic [7:0] wr_q [REG_NUM];
  logic [7:0] rd_q [REG_NUM];
  logic [7:0] wr_n [REG_NUM];
  logic [7:0] rd_n [REG_NUM];

  logic             atn_n, link_n, go_n;
  logic [7:0]       cmd_n;
  logic             fifo_push, fifo_pop, fifo_flush, soft_rst;
  logic [7:0]       fifo_q;
  logic [CNT_W-1:0] fifo_cnt;
  logic [4:0]       cnt5;
  logic [7:0]       rd_mux, rdata_q;
  logic             sel_fifo_q;
  logic             cmd_wr, intr_rd;
  cmd_kind_e        kind;

  srf_cmd_decode u_dec (
    .code (acc_wdata[6:0]),
    .kind (kind)
  );

  srf_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (fifo_flush || soft_rst),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .wdata (acc_wdata),
    .rdata (fifo_q),
    .count (fifo_cnt)
  );

  assign cnt5    = 5'(fifo_cnt);
  assign cmd_wr  = acc && acc_wr && (acc_idx == IX_CMD);
  assign intr_rd = acc && !acc_wr && (acc_idx == IX_INTR);

  always_comb begin
    wr_n       = wr_q;
    rd_n       = rd_q;
    atn_n      = atn;
    link_n     = link_up;
    go_n       = 1'b0;
    cmd_n      = seq_cmd;
    fifo_push  = 1'b0;
    fifo_pop   = 1'b0;
    fifo_flush = 1'b0;
    soft_rst   = 1'b0;
    if (acc && acc_wr) begin
      wr_n[acc_idx] = acc_wdata;
      if (mirrored(acc_idx)) rd_n[acc_idx] = acc_wdata;
      if (acc_idx == IX_FIFO) fifo_push = 1'b1;
      if (acc_idx == IX_CMD) begin
        rd_n[IX_INTR][IN_BUSRST] = 1'b0;
        if (acc_wdata[CMD_DMA]) begin
          rd_n[IX_TCL]        = wr_q[IX_TCL];
          rd_n[IX_TCM]        = wr_q[IX_TCM];
          rd_n[IX_TCH]        = wr_q[IX_TCH];
          rd_n[IX_STAT][ST_TC] = 1'b0;
        end
        case (kind)
          CK_FLUSH:   fifo_flush = 1'b1;
          CK_CHIPRST: soft_rst   = 1'b1;
          CK_BUSRST: begin
            if (!wr_q[IX_CFG1][CF1_RSTMASK]) rd_n[IX_STAT][ST_INT] = 1'b1;
            rd_n[IX_INTR][IN_BUSRST]   = 1'b1;
            rd_n[IX_INTR][IN_FUNCDONE] = 1'b1;
            link_n = 1'b0;
          end
          CK_MSGOK: begin
            rd_n[IX_STAT][ST_INT]  = 1'b1;
            rd_n[IX_INTR][IN_DISC] = 1'b1;
            rd_n[IX_STEP][2:0]     = STEP_DONE;
            link_n = 1'b0;
          end
          CK_SETATN: atn_n = 1'b1;
          CK_CLRATN: atn_n = 1'b0;
          CK_SELECT: begin
            go_n   = 1'b1;
            cmd_n  = acc_wdata;
            link_n = 1'b1;
          end
          CK_XFER: begin
            go_n  = 1'b1;
            cmd_n = acc_wdata;
          end
          CK_ILLEGAL: begin
            rd_n[IX_STAT][ST_INT]     = 1'b1;
            rd_n[IX_INTR][IN_ILLEGAL] = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (acc) begin
      if (acc_idx == IX_FIFO) fifo_pop = 1'b1;
      if (acc_idx == IX_INTR && rd_q[IX_STAT][ST_INT]) begin
        rd_n[IX_INTR] = 8'h00;
        rd_n[IX_STEP] = 8'h00;
        rd_n[IX_STAT] = {5'b0, PHASE_CMD};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      for (int i = 0; i < REG_NUM; i++) begin
        wr_q[i] <= wr_init(4'(i));
        rd_q[i] <= (4'(i) == IX_STEP) ? 8'h00 : wr_init(4'(i));
      end
      atn     <= 1'b0;
      link_up <= 1'b0;
      seq_go  <= 1'b0;
      seq_cmd <= 8'h00;
      irq     <= 1'b0;
    end else begin
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      atn     <= atn_n;
      link_up <= link_n;
      seq_go  <= go_n;
      seq_cmd <= cmd_n;
      irq     <= rd_q[IX_STAT][ST_INT];
    end
  end

  always_comb begin
    case (acc_idx)
      IX_FLAGS: rd_mux = {rd_q[IX_STEP][2:0], cnt5};
      IX_CFG1:  rd_mux = {rd_q[IX_CFG1][7:3], BUS_ID};
      default:  rd_mux = rd_q[acc_idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= 8'h00;
      sel_fifo_q <= 1'b0;
    end else if (acc && !acc_wr) begin
      rdata_q    <= rd_mux;
      sel_fifo_q <= (acc_idx == IX_FIFO);
    end
  end

  assign acc_rdata = sel_fifo_q ? fifo_q : rdata_q;

  // R11
  intr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (intr_rd && rd_q[IX_STAT][ST_INT]) |=>
      (rd_q[IX_STAT] == 8'h02 && rd_q[IX_INTR] == 8'h00 && rd_q[IX_STEP] == 8'h00));

  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (intr_rd && rd_q[IX_STAT][ST_INT]) |=> ##1 !irq);

  // R9
  busrst_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && kind != CK_BUSRST) |=> !rd_q[IX_INTR][IN_BUSRST]);

  // R8
  dma_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && acc_wdata[CMD_DMA] && kind != CK_CHIPRST) |=>
      (rd_q[IX_TCL] == $past(wr_q[IX_TCL]) && !rd_q[IX_STAT][ST_TC]));

  // R3
  own_id_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !acc_wr && acc_idx == IX_CFG1) |=> (acc_rdata[2:0] == BUS_ID));

  // R12
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seq_go |=> !seq_go);
endmodule

// File: tb/test_scsi_regfront.sv
module test_scsi_regfront;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc = 1'b0;
  logic       acc_wr = 1'b0;
  logic [3:0] acc_idx = 4'd0;
  logic [7:0] acc_wdata = 8'd0;
  logic [7:0] acc_rdata;
  logic       irq, atn, link_up, seq_go;
  logic [7:0] seq_cmd;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  scsi_regfront i_scsi_regfront (
    .clk(clk), .rst(rst), .acc(acc), .acc_wr(acc_wr), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq(irq), .atn(atn),
    .link_up(link_up), .seq_go(seq_go), .seq_cmd(seq_cmd)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] idx, input logic [7:0] d);
    acc = 1'b1; acc_wr = 1'b1; acc_idx = idx; acc_wdata = d;
    @(posedge clk); @(negedge clk);
    acc = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] idx, output logic [7:0] d);
    acc = 1'b1; acc_wr = 1'b0; acc_idx = idx;
    @(posedge clk); @(negedge clk);
    acc = 1'b0;
    d = acc_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v, e;
    for (int i = 0; i < 16; i++) begin
      bus_rd(4'(i), v);
      case (i)
        8:  e = 8'h07;
        9:  e = 8'h02;
        14: e = 8'h94;
        default: e = 8'h00;
      endcase
      chk($sformatf("R1 reset idx %0d", i), v, e);
    end
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    chk("R1 reset atn/link/go", {5'b0, atn, link_up, seq_go}, 8'h00);
  endtask

  task automatic t_mirror();
    logic [7:0] v;
    bus_wr(4'd11, 8'hA5); bus_rd(4'd11, v); chk("R2 mirror idx 11", v, 8'hA5);
    bus_wr(4'd10, 8'h5A); bus_rd(4'd10, v); chk("R2 mirror idx 10", v, 8'h5A);
    bus_wr(4'd0, 8'h34);  bus_rd(4'd0, v);  chk("R2 counter not mirrored", v, 8'h00);
    bus_wr(4'd8, 8'h10);  bus_rd(4'd8, v);  chk("R3 cfg1 own id", v, 8'h17);
    bus_wr(4'd8, 8'h00);  bus_rd(4'd8, v);  chk("R3 cfg1 id with zero write", v, 8'h07);
  endtask

  task automatic t_fifo();
    logic [7:0] v;
    bus_wr(4'd2, 8'h11); bus_wr(4'd2, 8'h22); bus_wr(4'd2, 8'h33);
    bus_rd(4'd7, v); chk("R5 flags count 3", v, 8'h03);
    bus_rd(4'd2, v); chk("R4 pop 1", v, 8'h11);
    bus_rd(4'd2, v); chk("R4 pop 2", v, 8'h22);
    bus_rd(4'd2, v); chk("R4 pop 3", v, 8'h33);
    for (int i = 0; i < 20; i++) bus_wr(4'd2, 8'(8'h40 + i));
    bus_rd(4'd7, v); chk("R4 full count 16", v, 8'h10);
    for (int i = 0; i < 16; i++) begin
      bus_rd(4'd2, v); chk($sformatf("R4 wrap pop %0d", i), v, 8'(8'h40 + i));
    end
    bus_rd(4'd7, v); chk("R5 flags empty", v, 8'h00);
    bus_rd(4'd2, v); chk("R6 empty read repeats last", v, 8'h4F);
    bus_rd(4'd7, v); chk("R6 count stays 0", v, 8'h00);
  endtask

  task automatic t_flush();
    logic [7:0] v;
    for (int i = 0; i < 5; i++) bus_wr(4'd2, 8'(i));
    bus_wr(4'd3, 8'h01);
    bus_rd(4'd7, v); chk("R7 flush empties", v, 8'h00);
    bus_wr(4'd2, 8'h99);
    bus_rd(4'd2, v); chk("R7 fifo usable after flush", v, 8'h99);
  endtask

  task automatic t_dma();
    logic [7:0] v;
    bus_wr(4'd0, 8'h34); bus_wr(4'd1, 8'h12); bus_wr(4'd14, 8'h56);
    bus_wr(4'd3, 8'h00);
    bus_rd(4'd0, v); chk("R8 no copy without flag", v, 8'h00);
    bus_wr(4'd3, 8'h80);
    bus_rd(4'd0, v);  chk("R8 low copied", v, 8'h34);
    bus_rd(4'd1, v);  chk("R8 mid copied", v, 8'h12);
    bus_rd(4'd14, v); chk("R8 high copied", v, 8'h56);
    bus_rd(4'd3, v);  chk("R2 command readback", v, 8'h80);
    bus_rd(4'd4, v);  chk("R8 terminal count clear", v, 8'h00);
    bus_wr(4'd0, 8'h77); bus_wr(4'd3, 8'h00);
    bus_rd(4'd0, v); chk("R8 plain command keeps count", v, 8'h34);
  endtask

  task automatic t_busreset();
    logic [7:0] v;
    bus_wr(4'd3, 8'h03);
    chk("R10 irq lags one clock", {7'b0, irq}, 8'h00);
    bus_rd(4'd4, v); chk("R10 status int set", v, 8'h80);
    chk("R10 irq high", {7'b0, irq}, 8'h01);
    bus_rd(4'd5, v); chk("R10 interrupt bits", v, 8'h88);
    bus_rd(4'd4, v); chk("R11 status to command phase", v, 8'h02);
    chk("R11 irq falls", {7'b0, irq}, 8'h00);
    bus_rd(4'd5, v); chk("R11 interrupt cleared", v, 8'h00);
    bus_rd(4'd6, v); chk("R11 step cleared", v, 8'h00);
  endtask

  task automatic t_masked();
    logic [7:0] v;
    bus_wr(4'd8, 8'h40);
    bus_wr(4'd3, 8'h03);
    idle(2);
    chk("R10 masked no irq", {7'b0, irq}, 8'h00);
    bus_rd(4'd4, v); chk("R10 masked status", v, 8'h02);
    bus_rd(4'd5, v); chk("R10 masked bits", v, 8'h88);
    bus_rd(4'd5, v); chk("R11 no clear without int", v, 8'h88);
    bus_wr(4'd3, 8'h00);
    bus_rd(4'd5, v); chk("R9 bus reset bit cleared", v, 8'h08);
    bus_wr(4'd8, 8'h00);
  endtask

  task automatic t_select_msgok();
    logic [7:0] v;
    bus_wr(4'd3, 8'h42);
    chk("R12 select go", {7'b0, seq_go}, 8'h01);
    chk("R12 select code", seq_cmd, 8'h42);
    chk("R12 link up", {7'b0, link_up}, 8'h01);
    idle(1);
    chk("R12 go one cycle", {7'b0, seq_go}, 8'h00);
    bus_wr(4'd3, 8'h10);
    chk("R12 transfer go", {7'b0, seq_go}, 8'h01);
    chk("R12 transfer code", seq_cmd, 8'h10);
    bus_wr(4'd3, 8'h12);
    chk("R12 msg accept link down", {7'b0, link_up}, 8'h00);
    bus_rd(4'd4, v); chk("R12 msg accept status", v, 8'h82);
    bus_rd(4'd7, v); chk("R5 flags show step 4", v, 8'h80);
    bus_rd(4'd6, v); chk("R12 step 4", v, 8'h04);
    bus_rd(4'd5, v); chk("R12 disconnect bit", v, 8'h28);
    bus_rd(4'd4, v); chk("R11 cleared after msg accept", v, 8'h02);
  endtask

  task automatic t_atn_illegal();
    logic [7:0] v;
    bus_wr(4'd3, 8'h1A); chk("R13 atn set", {7'b0, atn}, 8'h01);
    bus_wr(4'd3, 8'h1B); chk("R13 atn clear", {7'b0, atn}, 8'h00);
    bus_wr(4'd3, 8'h44);
    bus_rd(4'd4, v); chk("R14 code 44 no interrupt", v, 8'h02);
    bus_wr(4'd3, 8'h27);
    bus_rd(4'd4, v); chk("R14 illegal status", v, 8'h82);
    bus_rd(4'd5, v); chk("R14 illegal bit", v, 8'h40);
    bus_rd(4'd4, v); chk("R14 cleared after read", v, 8'h02);
  endtask

  task automatic t_chip_reset();
    logic [7:0] v;
    bus_wr(4'd11, 8'h33); bus_wr(4'd2, 8'hEE); bus_wr(4'd3, 8'h1A);
    bus_wr(4'd3, 8'h02);
    chk("R1 chip reset atn", {7'b0, atn}, 8'h00);
    bus_rd(4'd11, v); chk("R1 chip reset cfg2", v, 8'h00);
    bus_rd(4'd7, v);  chk("R1 chip reset fifo", v, 8'h00);
    bus_rd(4'd14, v); chk("R1 chip reset count high", v, 8'h94);
    bus_rd(4'd9, v);  chk("R1 chip reset clock factor", v, 8'h02);
    bus_rd(4'd3, v);  chk("R1 chip reset command", v, 8'h00);
    bus_rd(4'd4, v);  chk("R1 chip reset status", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mirror();
    t_fifo();
    t_flush();
    t_dma();
    t_busreset();
    t_masked();
    t_select_msgok();
    t_atn_illegal();
    t_chip_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule